// File: doc/BRIEF.md
# I2C Master Interrupt Status and Mask Unit

This unit gathers the event and request signals of an I2C master engine into one 8-bit status view and drives a single interrupt line. Six of the sources are single-cycle event pulses from the FIFO and bus engine: packet complete, all packets complete, transmit FIFO overflow, receive FIFO underflow, missing acknowledge and lost arbitration. Each pulse sets a sticky bit that holds until software clears it by writing a one to that bit. The other two sources are live level requests from the FIFOs: transmit wants data, receive has data. They show their current level and cannot be cleared. A mask register, with the same bit layout, selects which status bits may raise the interrupt. The interrupt output is registered.

Software clears serviced events by writing back the status value it read. A build parameter can make the packet-complete source bypass its mask bit, so it always reaches the interrupt line. A second build parameter adds the wrapper status register used when the controller sits inside a voltage-controller shell. In that register, bit 30 is a sticky done flag. It is set by either completion event and cleared by writing a one to bit 30.

Register access uses a simple strobe. A write takes effect at the clock edge where `reg_wr_i` is high. Read data is a combinational function of `reg_addr_i`. The address map is: 0 status, 1 mask, 2 wrapper status, 3 unused. None of these paths carries flowing data, so the unit has no valid/ready interface.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: A pulse on an event input sets its sticky status bit at the next edge, and the bit stays set until cleared. The bit positions are: packet complete 7, all packets complete 6, TX overflow 5, RX underflow 4, missing acknowledge 3, arbitration lost 2.
- R2: Status bit 1 always equals `tx_req_i` and bit 0 always equals `rx_req_i`, in the same cycle. Writing the status register does not change them.
- R3: A write to address 0 clears every sticky bit whose write-data bit is 1 and leaves the bits whose write-data bit is 0 unchanged. An event arriving in the same cycle as its clear leaves the bit set.
- R4: The mask register at address 1 stores write-data bits 7:0 and reads back in bits 7:0. Its upper read bits are 0.
- R5: `irq_o` is high in the cycle after any status bit is 1 while its effective mask bit is 1. Otherwise `irq_o` is low.
- R6: With `PKT_MASKABLE` = 0, status bit 7 raises `irq_o` whatever mask bit 7 holds. With `PKT_MASKABLE` = 1, mask bit 7 gates it like any other bit.
- R7: With `WRAPPED` = 1, bit 30 of address 2 is set by a packet-complete or all-packets-complete pulse. It is cleared by a write to address 2 with write-data bit 30 at 1, and a completion event in the same cycle wins. Writes with bit 30 at 0 leave it unchanged. All other bits of address 2 read 0.
- R8: With `WRAPPED` = 0, address 2 reads 0 at all times.
- R9: After reset, the sticky bits, the mask, the wrapper done flag and `irq_o` are 0. Address 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_done_i | input | 1 | Packet complete event pulse |
| all_done_i | input | 1 | All packets complete event pulse |
| tx_ovf_i | input | 1 | TX FIFO overflow event pulse |
| rx_unf_i | input | 1 | RX FIFO underflow event pulse |
| nack_i | input | 1 | Missing acknowledge event pulse |
| arb_lost_i | input | 1 | Arbitration lost event pulse |
| tx_req_i | input | 1 | Live TX FIFO data request level |
| rx_req_i | input | 1 | Live RX FIFO data request level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A wrong sticky bit or mask bit shows up on `reg_rdata_o` at once, because reads are combinational. The same error reaches `irq_o` exactly one edge later. The bench therefore reads a register in every cycle and compares `irq_o` after every edge. A lost or extra event, a clear that hits the wrong bit, or a live request bit that gets latched is caught within one cycle. A second instance, built without the packet mask and without the wrapper, runs on the same stimulus. This exposes any error in those parameter choices as a difference between the two instances' interrupt lines and wrapper reads.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NUM_SRC    = 8;
  localparam int NUM_LIVE   = 2;
  localparam int NUM_STICKY = NUM_SRC - NUM_LIVE;
  localparam int REG_AW     = 2;

  localparam int BIT_PKT_DONE = 7;
  localparam int BIT_ALL_DONE = 6;
  localparam int BIT_TX_OVF   = 5;
  localparam int BIT_RX_UNF   = 4;
  localparam int BIT_NACK     = 3;
  localparam int BIT_ARB_LOST = 2;
  localparam int BIT_TX_REQ   = 1;
  localparam int BIT_RX_REQ   = 0;

  typedef enum logic [REG_AW-1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_WRAP   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  // One flop per source; a set in the same cycle as a clear wins.
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          bit_q <= 1'b0;
      else if (set_i[g])    bit_q <= 1'b1;
      else if (clr_i[g])    bit_q <= 1'b0;
    end
    assign q_o[g] = bit_q;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int WIDTH        = 8,
  parameter bit PKT_MASKABLE = 1'b1,
  parameter int PKT_BIT      = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] mask_o,
  output logic [WIDTH-1:0] eff_mask_o
);
  logic [WIDTH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  if (PKT_MASKABLE) begin : g_masked
    assign eff_mask_o = mask_q;
  end else begin : g_forced
    always_comb begin
      eff_mask_o          = mask_q;
      eff_mask_o[PKT_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_wrap_status.sv
module irq_wrap_status #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic done_o
);
  if (ENABLE) begin : g_on
    logic done_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    done_q <= 1'b0;
      else if (set_i) done_q <= 1'b1;
      else if (clr_i) done_q <= 1'b0;
    end
    assign done_o = done_q;
  end else begin : g_off
    logic unused_wrap_in;
    assign unused_wrap_in = clk_i ^ rst_ni ^ set_i ^ clr_i;
    assign done_o = 1'b0;
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] status_i,
  input  logic [WIDTH-1:0] enable_i,
  output logic             irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_i & enable_i);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter bit PKT_MASKABLE = 1'b1,
  parameter bit WRAPPED      = 1'b1,
  parameter int WRAP_BIT     = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_done_i,
  input  logic              all_done_i,
  input  logic              tx_ovf_i,
  input  logic              rx_unf_i,
  input  logic              nack_i,
  input  logic              arb_lost_i,
  input  logic              tx_req_i,
  input  logic              rx_req_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int UPPER_W = DATA_W - NUM_SRC;

  reg_sel_e              sel;
  logic [NUM_STICKY-1:0] sticky_set;
  logic [NUM_STICKY-1:0] sticky_clr;
  logic [NUM_STICKY-1:0] sticky_q;
  logic [NUM_SRC-1:0]    status_w;
  logic [NUM_SRC-1:0]    mask_q;
  logic [NUM_SRC-1:0]    eff_mask;
  logic                  wr_status, wr_mask, wr_wrap;
  logic                  wrap_done;
  logic [UPPER_W-1:0]    unused_wdata;

  assign sel       = reg_sel_e'(reg_addr_i);
  assign wr_status = reg_wr_i && (sel == SEL_STATUS);
  assign wr_mask   = reg_wr_i && (sel == SEL_MASK);
  assign wr_wrap   = reg_wr_i && (sel == SEL_WRAP);

  // Sticky index k maps to status bit k + NUM_LIVE.
  always_comb begin
    sticky_set = '0;
    sticky_set[BIT_PKT_DONE - NUM_LIVE] = pkt_done_i;
    sticky_set[BIT_ALL_DONE - NUM_LIVE] = all_done_i;
    sticky_set[BIT_TX_OVF   - NUM_LIVE] = tx_ovf_i;
    sticky_set[BIT_RX_UNF   - NUM_LIVE] = rx_unf_i;
    sticky_set[BIT_NACK     - NUM_LIVE] = nack_i;
    sticky_set[BIT_ARB_LOST - NUM_LIVE] = arb_lost_i;
  end

  assign sticky_clr = wr_status ? reg_wdata_i[NUM_SRC-1:NUM_LIVE] : '0;

  irq_sticky_bank #(.WIDTH(NUM_STICKY)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sticky_set),
    .clr_i  (sticky_clr),
    .q_o    (sticky_q)
  );

  always_comb begin
    status_w                         = '0;
    status_w[NUM_SRC-1:NUM_LIVE]     = sticky_q;
    status_w[BIT_TX_REQ]             = tx_req_i;
    status_w[BIT_RX_REQ]             = rx_req_i;
  end

  irq_mask_reg #(
    .WIDTH        (NUM_SRC),
    .PKT_MASKABLE (PKT_MASKABLE),
    .PKT_BIT      (BIT_PKT_DONE)
  ) u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_mask),
    .wdata_i    (reg_wdata_i[NUM_SRC-1:0]),
    .mask_o     (mask_q),
    .eff_mask_o (eff_mask)
  );

  irq_wrap_status #(.ENABLE(WRAPPED)) u_wrap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (pkt_done_i | all_done_i),
    .clr_i  (wr_wrap & reg_wdata_i[WRAP_BIT]),
    .done_o (wrap_done)
  );

  irq_out_stage #(.WIDTH(NUM_SRC)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_w),
    .enable_i (eff_mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_STATUS: reg_rdata_o[NUM_SRC-1:0] = status_w;
      SEL_MASK:   reg_rdata_o[NUM_SRC-1:0] = mask_q;
      SEL_WRAP:   reg_rdata_o[WRAP_BIT]    = wrap_done;
      default:    reg_rdata_o              = '0;
    endcase
  end

  assign unused_wdata = reg_wdata_i[DATA_W-1:NUM_SRC];
endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
module i2c_irq_ctrl_chk #(
  parameter int DATA_W       = 32,
  parameter bit PKT_MASKABLE = 1'b1,
  parameter bit WRAPPED      = 1'b1,
  parameter int WRAP_BIT     = 30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_req_i,
  input logic              rx_req_i,
  input logic              reg_wr_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [5:0]        sticky_set,
  input logic [7:0]        status_w,
  input logic [7:0]        mask_q,
  input logic              wrap_done,
  input logic              irq_o
);
  p_sticky_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_set != 6'd0) |=> ((status_w[7:2] & $past(sticky_set)) == $past(sticky_set)));

  p_sticky_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == 2'd0)
      |=> ((status_w[7:2] & $past(status_w[7:2])) == $past(status_w[7:2])));

  p_live_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_w[1:0] == {tx_req_i, rx_req_i});

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd0 && ((reg_wdata_i[7:2] & sticky_set) == 6'd0))
      |=> ((status_w[7:2] & $past(reg_wdata_i[7:2])) == 6'd0));

  p_irq_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_w & mask_q) != 8'd0) |=> irq_o);

  p_irq_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == 8'd0 && (PKT_MASKABLE || !status_w[7])) |=> !irq_o);

  p_pkt_force_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!PKT_MASKABLE && status_w[7]) |=> irq_o);

  p_wrap_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WRAPPED && (sticky_set[5] || sticky_set[4])) |=> wrap_done);

  p_wrap_absent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !WRAPPED |-> !wrap_done);
endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk #(
  .DATA_W       (DATA_W),
  .PKT_MASKABLE (PKT_MASKABLE),
  .WRAPPED      (WRAPPED),
  .WRAP_BIT     (WRAP_BIT)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_req_i    (tx_req_i),
  .rx_req_i    (rx_req_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .sticky_set  (sticky_set),
  .status_w    (status_w),
  .mask_q      (mask_q),
  .wrap_done   (wrap_done),
  .irq_o       (irq_o)
);

// File: tb/i2c_irq_ctrl_tb_top.sv
module i2c_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ev = '0;     // {pkt, all, txovf, rxunf, nack, arb}
  logic [1:0]  rq = '0;     // {tx_req, rx_req}
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_nm;
  logic        irq, irq_nm;

  int checks = 0;
  int errors = 0;

  logic [5:0] m_sticky = '0;
  logic [7:0] m_mask = '0;
  logic       m_wrap = 1'b0;
  logic       m_irq = 1'b0;
  logic       m_irq_nm = 1'b0;

  always #4 clk = ~clk;

  i2c_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .pkt_done_i(ev[5]), .all_done_i(ev[4]), .tx_ovf_i(ev[3]),
    .rx_unf_i(ev[2]), .nack_i(ev[1]), .arb_lost_i(ev[0]),
    .tx_req_i(rq[1]), .rx_req_i(rq[0]),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  i2c_irq_ctrl #(.PKT_MASKABLE(1'b0), .WRAPPED(1'b0)) dut_nm (
    .clk_i(clk), .rst_ni(rst_n),
    .pkt_done_i(ev[5]), .all_done_i(ev[4]), .tx_ovf_i(ev[3]),
    .rx_unf_i(ev[2]), .nack_i(ev[1]), .arb_lost_i(ev[0]),
    .tx_req_i(rq[1]), .rx_req_i(rq[0]),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_nm), .irq_o(irq_nm)
  );

  function automatic logic [31:0] exp_read(input logic [1:0] a, input bit nm);
    case (a)
      2'd0:    return {24'd0, m_sticky, rq};
      2'd1:    return {24'd0, m_mask};
      2'd2:    return nm ? 32'd0 : (32'(m_wrap) << 30);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, check read, model edge, check irq.
  task automatic cyc(input string tag, input logic [5:0] e, input logic [1:0] r,
                     input logic w, input logic [1:0] a, input logic [31:0] d);
    logic [7:0] st;
    @(negedge clk);
    ev = e; rq = r; wr = w; addr = a; wdata = d;
    #1;
    if (!w) begin
      check({tag, " read"}, rdata, exp_read(a, 1'b0));
      check({tag, " read nm"}, rdata_nm, exp_read(a, 1'b1));
    end
    @(posedge clk);
    st = {m_sticky, r};
    m_irq    = |(st & m_mask);
    m_irq_nm = |(st & (m_mask | 8'h80));
    if (w && a == 2'd0) m_sticky = m_sticky & ~d[7:2];
    m_sticky = m_sticky | e;
    if (w && a == 2'd1) m_mask = d[7:0];
    if (w && a == 2'd2 && d[30]) m_wrap = 1'b0;
    if (e[5] || e[4]) m_wrap = 1'b1;
    #1;
    check({tag, " irq"}, 32'(irq), 32'(m_irq));
    check({tag, " irq nm"}, 32'(irq_nm), 32'(m_irq_nm));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R9: reset state, unused address
    cyc("R9", 6'd0, 2'b00, 1'b0, 2'd0, 32'd0);
    cyc("R9", 6'd0, 2'b00, 1'b0, 2'd1, 32'd0);
    cyc("R9", 6'd0, 2'b00, 1'b0, 2'd2, 32'd0);
    cyc("R9", 6'd0, 2'b00, 1'b0, 2'd3, 32'd0);
    // R1: each event sets its bit and holds
    for (int k = 0; k < 6; k++) begin
      cyc("R1", 6'(1 << k), 2'b00, 1'b0, 2'd0, 32'd0);
      cyc("R1", 6'd0, 2'b00, 1'b0, 2'd0, 32'd0);
    end
    cyc("R1", 6'd0, 2'b00, 1'b0, 2'd0, 32'd0);
    // R2: live bits follow inputs and survive a clear of all ones
    cyc("R2", 6'd0, 2'b11, 1'b1, 2'd0, 32'h0000_00FF);
    cyc("R2", 6'd0, 2'b11, 1'b0, 2'd0, 32'd0);
    cyc("R2", 6'd0, 2'b10, 1'b0, 2'd0, 32'd0);
    cyc("R2", 6'd0, 2'b01, 1'b0, 2'd0, 32'd0);
    // R3: partial clear, zero write, event beats clear
    cyc("R3", 6'h3F, 2'b00, 1'b0, 2'd0, 32'd0);
    cyc("R3", 6'd0, 2'b00, 1'b1, 2'd0, 32'h0000_0028);
    cyc("R3", 6'd0, 2'b00, 1'b0, 2'd0, 32'd0);
    cyc("R3", 6'd0, 2'b00, 1'b1, 2'd0, 32'd0);
    cyc("R3", 6'b000010, 2'b00, 1'b1, 2'd0, 32'h0000_00FC);
    cyc("R3", 6'd0, 2'b00, 1'b0, 2'd0, 32'd0);
    cyc("R3", 6'd0, 2'b00, 1'b1, 2'd0, 32'h0000_00FC);
    cyc("R3", 6'd0, 2'b00, 1'b0, 2'd0, 32'd0);
    // R4: mask stores low byte only
    cyc("R4", 6'd0, 2'b00, 1'b1, 2'd1, 32'hFFFF_FF5A);
    cyc("R4", 6'd0, 2'b00, 1'b0, 2'd1, 32'd0);
    // R5: a masked source raises irq one cycle later; unmasked does not
    cyc("R5", 6'd0, 2'b00, 1'b1, 2'd1, 32'h0000_0008);
    cyc("R5", 6'b000001, 2'b00, 1'b0, 2'd0, 32'd0);
    cyc("R5", 6'b000010, 2'b00, 1'b0, 2'd0, 32'd0);
    cyc("R5", 6'd0, 2'b00, 1'b0, 2'd0, 32'd0);
    cyc("R5", 6'd0, 2'b00, 1'b1, 2'd0, 32'h0000_00FF);
    cyc("R5", 6'd0, 2'b00, 1'b1, 2'd1, 32'h0000_0002);
    cyc("R5", 6'd0, 2'b10, 1'b0, 2'd0, 32'd0);
    cyc("R5", 6'd0, 2'b00, 1'b0, 2'd0, 32'd0);
    // R6: packet complete with mask cleared
    cyc("R6", 6'd0, 2'b00, 1'b1, 2'd1, 32'd0);
    cyc("R6", 6'b100000, 2'b00, 1'b0, 2'd0, 32'd0);
    cyc("R6", 6'd0, 2'b00, 1'b0, 2'd0, 32'd0);
    cyc("R6", 6'd0, 2'b00, 1'b1, 2'd0, 32'h0000_0080);
    cyc("R6", 6'd0, 2'b00, 1'b0, 2'd0, 32'd0);
    // R7 / R8: wrapper done flag
    cyc("R7", 6'b010000, 2'b00, 1'b0, 2'd2, 32'd0);
    cyc("R7", 6'd0, 2'b00, 1'b1, 2'd2, 32'hBFFF_FFFF);
    cyc("R8", 6'd0, 2'b00, 1'b0, 2'd2, 32'd0);
    cyc("R7", 6'd0, 2'b00, 1'b1, 2'd2, 32'h4000_0000);
    cyc("R7", 6'd0, 2'b00, 1'b0, 2'd2, 32'd0);
    cyc("R7", 6'b100000, 2'b00, 1'b1, 2'd2, 32'h4000_0000);
    cyc("R7", 6'd0, 2'b00, 1'b0, 2'd2, 32'd0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [5:0]  re;
      logic [1:0]  rr, ra;
      logic        rw;
      logic [31:0] rd;
      re = 6'($urandom) & 6'($urandom) & 6'($urandom);
      rr = 2'($urandom);
      rw = ($urandom % 4) == 0;
      ra = 2'($urandom);
      rd = $urandom;
      cyc("R1 R3 R5 random", re, rr, rw, ra, rd);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule